// File: doc/BRIEF.md
# Serial Link Lane Test Pattern Generator

This block is the built-in self-test source for one lane of a serial link that carries 10-bit characters. Every clock it produces one character. A one-hot select picks the source of that character: a constant zero, the normal data word from the encoder, a pseudo-random bit sequence, or a programmable cyclic word pattern. The serialiser and the physical layer sit downstream and are not part of this block.

The PRBS source holds a linear feedback shift register. It runs one of four polynomials of degree 7, 11, 15 or 31. It can deliver a 10-bit word, an 8-bit word or a single bit per clock, and the register advances by the matching number of steps. The pattern source steps through eight 10-bit words taken from an 80-bit store. It holds each word for one to eight clocks. Each generator has its own enable. Clearing an enable returns that generator to its start point: the seed for the PRBS, the first word for the pattern.

The output is registered, so the character on `char_out` reflects the inputs sampled at the previous rising clock edge.

Top module: `lane_pattern_gen`

## Requirements
- R1: While `rst_n` is low, `char_out` is 0. At reset the LFSR holds all ones and the pattern source points at its first word with the hold count at 0.
- R2: `char_out` is registered and selected by `out_sel`: 3'b000 gives zero, 3'b001 gives `data_in`, 3'b010 gives the PRBS word and 3'b100 gives the pattern word. Any other code gives zero.
- R3: While `prbs_en` is 0, the PRBS word is 0 and the LFSR is reloaded with all ones on every clock.
- R4: `prbs_poly` selects the feedback: 0 = x^11+x^9+1, 1 = x^15+x^14+1, 2 = x^7+x^6+1, 3 = x^31+x^28+1. For degree n with taps a and b, one step shifts the low n bits of the state left by one and inserts the new bit s[a-1]^s[b-1] at bit 0.
- R5: With `prbs_width` = 3 the LFSR takes 10 steps per clock. The 10 new bits form the word, with the first new bit in bit 9 and the last in bit 0.
- R6: With `prbs_width` = 1 the LFSR takes 8 steps per clock. The new bits fill bits 7:0, first bit in bit 7, and bits 9:8 are 0.
- R7: With `prbs_width` = 2 the LFSR takes 1 step per clock. The new bit is in bit 0 and bits 9:1 are 0.
- R8: With `prbs_width` = 0 (idle) the PRBS word is 0 and the LFSR state is held. The sequence continues from where it stopped once a width is selected again.
- R9: The pattern source emits `shift_words` bits 79:70 first, then 69:60, and so on down to bits 9:0. It then wraps back to 79:70.
- R10: With `shift_hold` = R, each pattern word is presented for R+1 consecutive clocks. R ranges from 0 to 7.
- R11: While `shift_en` is 0, the pattern word is 0. The source returns to the first word with a zero hold count, so the next enable starts at bits 79:70.
- R12: The PRBS source and the pattern source keep running whether or not `out_sel` selects them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| out_sel | input | 3 | One-hot output source select |
| prbs_en | input | 1 | PRBS generator enable |
| prbs_poly | input | 2 | PRBS polynomial select |
| prbs_width | input | 2 | PRBS word width select |
| shift_en | input | 1 | Pattern generator enable |
| shift_hold | input | 3 | Pattern word hold, minus one |
| shift_words | input | 80 | Store of eight 10-bit pattern words |
| data_in | input | 10 | Normal character from the encoder |
| char_out | output | 10 | Output character |

## Verification
A wrong LFSR bit or a wrong feedback tap does not fade out. It shows up in the next PRBS word on `char_out`, one clock after the stepping edge, and it corrupts every later word. The bench therefore compares full words against an independent polynomial model over many consecutive clocks, for each polynomial and each width. A slip in the pattern index or the hold counter shows as a word arriving one clock early or late, or out of order. Hold values of 0, 2 and 7 are run across a full wrap, with enables toggled in between, so the order, the restart and the exact hold length are all observed at the output.

// File: rtl/lane_pattern_gen.sv
module lane_pattern_gen #(
  parameter int CW     = 10,
  parameter int NWORDS = 8,
  parameter int LW     = 31
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           out_sel,
  input  logic                 prbs_en,
  input  logic [1:0]           prbs_poly,
  input  logic [1:0]           prbs_width,
  input  logic                 shift_en,
  input  logic [2:0]           shift_hold,
  input  logic [NWORDS*CW-1:0] shift_words,
  input  logic [CW-1:0]        data_in,
  output logic [CW-1:0]        char_out
);

  localparam int IW = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(NWORDS - 1);

  logic [LW-1:0] lfsr_q, lfsr_d;
  logic [CW-1:0] prbs_word;
  logic [IW-1:0] idx_q;
  logic [2:0]    cnt_q;
  logic [CW-1:0] shift_word;
  logic [CW-1:0] sel_word;

  function automatic logic [LW-1:0] lfsr_step(input logic [LW-1:0] s, input logic [1:0] poly);
    logic          fb;
    logic [LW-1:0] m;
    case (poly)
      2'd0:    begin fb = s[10] ^ s[8];  m = LW'(32'h0000_07FF); end
      2'd1:    begin fb = s[14] ^ s[13]; m = LW'(32'h0000_7FFF); end
      2'd2:    begin fb = s[6]  ^ s[5];  m = LW'(32'h0000_007F); end
      default: begin fb = s[30] ^ s[27]; m = LW'(32'h7FFF_FFFF); end
    endcase
    return ((s << 1) | LW'(fb)) & m;
  endfunction

  always_comb begin
    logic [LW-1:0] st;
    int            nsteps;
    st = lfsr_q;
    prbs_word = '0;
    case (prbs_width)
      2'd1:    nsteps = CW - 2;
      2'd2:    nsteps = 1;
      2'd3:    nsteps = CW;
      default: nsteps = 0;
    endcase
    if (!prbs_en) nsteps = 0;
    for (int k = 0; k < CW; k++) begin
      if (k < nsteps) begin
        st = lfsr_step(st, prbs_poly);
        prbs_word = {prbs_word[CW-2:0], st[0]};
      end
    end
    lfsr_d = prbs_en ? st : '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= '1;
    else        lfsr_q <= lfsr_d;
  end

  assign shift_word = shift_en ? shift_words[(NWORDS-1-int'(idx_q))*CW +: CW] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      cnt_q <= '0;
    end else if (!shift_en) begin
      idx_q <= '0;
      cnt_q <= '0;
    end else if (cnt_q >= shift_hold) begin
      cnt_q <= '0;
      idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    case (out_sel)
      3'b001:  sel_word = data_in;
      3'b010:  sel_word = prbs_word;
      3'b100:  sel_word = shift_word;
      default: sel_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) char_out <= '0;
    else        char_out <= sel_word;
  end

endmodule

module lane_pattern_gen_chk #(
  parameter int CW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    out_sel,
  input logic          prbs_en,
  input logic [1:0]    prbs_width,
  input logic          shift_en,
  input logic [CW-1:0] data_in,
  input logic [CW-1:0] char_out
);

  always @(posedge clk) begin
    if (rst_n === 1'b0) p_reset_zero_r1: assert (char_out == '0);
  end

  p_pass_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_sel == 3'b001 |=> char_out == $past(data_in));

  p_bad_sel_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_sel inside {3'b001, 3'b010, 3'b100}) |=> char_out == '0);

  p_prbs_off_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sel == 3'b010 && !prbs_en) |=> char_out == '0);

  p_byte_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sel == 3'b010 && prbs_width == 2'd1) |=> char_out[CW-1:CW-2] == 2'b00);

  p_bit_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sel == 3'b010 && prbs_width == 2'd2) |=> char_out[CW-1:1] == '0);

  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sel == 3'b010 && prbs_width == 2'd0) |=> char_out == '0);

  p_shift_off_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sel == 3'b100 && !shift_en) |=> char_out == '0);

endmodule

bind lane_pattern_gen lane_pattern_gen_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_sel(out_sel), .prbs_en(prbs_en),
  .prbs_width(prbs_width), .shift_en(shift_en), .data_in(data_in),
  .char_out(char_out)
);

// File: tb/test_lane_pattern_gen.sv
`timescale 1ns/1ps
module test_lane_pattern_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  out_sel = '0;
  logic        prbs_en = 1'b0;
  logic [1:0]  prbs_poly = '0;
  logic [1:0]  prbs_width = '0;
  logic        shift_en = 1'b0;
  logic [2:0]  shift_hold = '0;
  logic [79:0] shift_words = '0;
  logic [9:0]  data_in = '0;
  logic [9:0]  char_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [9:0] exp_q[$];
  string      tag_q[$];

  logic [30:0] m_lfsr = '1;
  int          m_idx = 0;
  int          m_cnt = 0;

  always #4 clk = ~clk;

  lane_pattern_gen i_lane_pattern_gen (
    .clk(clk), .rst_n(rst_n), .out_sel(out_sel), .prbs_en(prbs_en),
    .prbs_poly(prbs_poly), .prbs_width(prbs_width), .shift_en(shift_en),
    .shift_hold(shift_hold), .shift_words(shift_words), .data_in(data_in),
    .char_out(char_out)
  );

  function automatic logic [30:0] ref_step(input logic [30:0] r, input logic [1:0] poly);
    int n, a, b;
    logic nb;
    logic [30:0] o;
    case (poly)
      2'd0: begin n = 11; a = 11; b = 9;  end
      2'd1: begin n = 15; a = 15; b = 14; end
      2'd2: begin n = 7;  a = 7;  b = 6;  end
      default: begin n = 31; a = 31; b = 28; end
    endcase
    nb = r[a-1] ^ r[b-1];
    o = '0;
    for (int i = 1; i < n; i++) o[i] = r[i-1];
    o[0] = nb;
    return o;
  endfunction

  task automatic apply(input logic [2:0] sel, input logic pen, input logic [1:0] poly,
                       input logic [1:0] pw, input logic sen, input logic [2:0] hold,
                       input logic [9:0] d, input string tag);
    logic [9:0] pword, sword, e;
    int steps;
    @(negedge clk);
    out_sel = sel; prbs_en = pen; prbs_poly = poly; prbs_width = pw;
    shift_en = sen; shift_hold = hold; data_in = d;
    steps = (!pen) ? 0 : (pw == 2'd3) ? 10 : (pw == 2'd1) ? 8 : (pw == 2'd2) ? 1 : 0;
    pword = '0;
    for (int k = 0; k < steps; k++) begin
      m_lfsr = ref_step(m_lfsr, poly);
      pword[steps-1-k] = m_lfsr[0];
    end
    if (!pen) m_lfsr = '1;
    sword = sen ? shift_words[79 - 10*m_idx -: 10] : '0;
    if (!sen) begin
      m_idx = 0; m_cnt = 0;
    end else if (m_cnt >= int'(hold)) begin
      m_cnt = 0; m_idx = (m_idx + 1) % 8;
    end else begin
      m_cnt++;
    end
    case (sel)
      3'b001: e = d;
      3'b010: e = pword;
      3'b100: e = sword;
      default: e = '0;
    endcase
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [9:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (char_out !== e) begin
        fails++;
        $display("FAIL %s: char_out=%h expected=%h", t, char_out, e);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) shift_words[79 - 10*i -: 10] = 10'(10'h0A1 * (i + 1) ^ (i << 7));
    data_in = 10'h3FF;
    out_sel = 3'b001;
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (char_out !== 10'h000) begin
        fails++;
        $display("FAIL R1: char_out=%h expected=000", char_out);
      end
    end
    rst_n = 1'b1;

    apply(3'b000, 0, 0, 0, 0, 0, 10'h155, "R2 zero code");
    apply(3'b001, 0, 0, 0, 0, 0, 10'h2AA, "R2 data");
    apply(3'b001, 0, 0, 0, 0, 0, 10'h155, "R2 data");
    foreach (exp_q[i]) ;
    apply(3'b011, 0, 0, 0, 0, 0, 10'h3FF, "R2 bad code 011");
    apply(3'b101, 0, 0, 0, 0, 0, 10'h3FF, "R2 bad code 101");
    apply(3'b110, 0, 0, 0, 0, 0, 10'h3FF, "R2 bad code 110");
    apply(3'b111, 0, 0, 0, 0, 0, 10'h3FF, "R2 bad code 111");
    apply(3'b010, 0, 0, 3, 0, 0, 10'h3FF, "R3 prbs off");

    for (int p = 0; p < 4; p++) begin
      apply(3'b010, 0, 2'(p), 3, 0, 0, 10'h0, "R3 reseed");
      for (int c = 0; c < 40; c++) apply(3'b010, 1, 2'(p), 3, 0, 0, 10'h0, "R4 R5 ten-bit");
      for (int c = 0; c < 10; c++) apply(3'b010, 1, 2'(p), 1, 0, 0, 10'h0, "R6 eight-bit");
      for (int c = 0; c < 20; c++) apply(3'b010, 1, 2'(p), 2, 0, 0, 10'h0, "R7 one-bit");
      for (int c = 0; c < 3; c++) apply(3'b010, 1, 2'(p), 0, 0, 0, 10'h0, "R8 idle");
      for (int c = 0; c < 5; c++) apply(3'b010, 1, 2'(p), 3, 0, 0, 10'h0, "R8 resume");
    end

    for (int c = 0; c < 6; c++) apply(3'b001, 1, 2'd3, 3, 0, 0, 10'(c * 37), "R12 prbs hidden");
    for (int c = 0; c < 8; c++) apply(3'b010, 1, 2'd3, 3, 0, 0, 10'h0, "R12 prbs continues");

    apply(3'b100, 0, 0, 0, 0, 0, 10'h0, "R11 shift off");
    for (int c = 0; c < 20; c++) apply(3'b100, 0, 0, 0, 1, 3'd0, 10'h0, "R9 order hold0");
    for (int c = 0; c < 30; c++) apply(3'b100, 0, 0, 0, 1, 3'd2, 10'h0, "R10 hold2");
    apply(3'b100, 0, 0, 0, 0, 3'd2, 10'h0, "R11 disable");
    for (int c = 0; c < 70; c++) apply(3'b100, 0, 0, 0, 1, 3'd7, 10'h0, "R10 R9 hold7 wrap");
    for (int c = 0; c < 5; c++) apply(3'b001, 0, 0, 0, 1, 3'd1, 10'h1C3, "R12 shift hidden");
    for (int c = 0; c < 12; c++) apply(3'b100, 0, 0, 0, 1, 3'd1, 10'h0, "R12 shift continues");
    apply(3'b100, 0, 0, 0, 0, 3'd1, 10'h0, "R11 disable again");
    for (int c = 0; c < 4; c++) apply(3'b100, 0, 0, 0, 1, 3'd0, 10'h0, "R11 restart first word");

    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule